// File: doc/BRIEF.md
# MSI-X Vector Table and Delivery Gate

This block sits on the device side of a multi-queue peripheral and turns abstract interrupt requests into message-signalled interrupts. The device core raises one of two kinds of request. A queue-completion request carries a queue index. A configuration-change request carries nothing else. Software has programmed a vector for each source through a small register space. The block looks up that vector and checks the global enable, the function-wide mask and the vector's own mask. It then either presents a 64-bit address and 32-bit data word on a message-write port, or records a pending bit.

A pending bit is replayed exactly once. This happens when software later clears that vector's mask bit and the vector is deliverable. The bit is cleared only when the replayed message has been taken. A virtio-level reset pulse wipes the source-to-vector assignments. It leaves the vector table, the pending bits and message control alone. With the default parameters there are six queues and at most four vectors, so several queues must share one vector.

Top module: `msix_vector_gate`

## Requirements
- R1: After reset every table entry reads back with vector-control bit 0 (the mask) set and all other dwords zero. Message control reads 0, the config vector and every queue-map entry read 0xFFFF, and the pending byte reads 0.
- R2: The table holds min(NUM_QUEUES+1, MAX_VECTORS) entries. The queue map still holds one entry for every queue, even when that limit cuts the table short.
- R3: A message-control write takes wdata bit 15 as the enable and bit 14 as the function mask. A read returns these two bits in the same positions. While the function mask is set, no vector delivers.
- R4: A config request uses the config vector, and a queue request uses that queue's map entry. The emitted message carries address {dword1, dword0} and data dword2 of the selected table entry (dword index selects: 0 address low, 1 address high, 2 data, 3 vector control).
- R5: A request whose vector is 0xFFFF, is at or beyond the table size, or arrives while the enable is clear produces no message and sets no pending bit.
- R6: A request to a vector that is masked (own mask or function mask) emits nothing. It sets bit (vector mod 8) of pending byte (vector / 8).
- R7: Only a write to dword 3 that changes the mask bit from 1 to 0 is an unmask edge. Writing mask=1, or writing any other dword, triggers no replay.
- R8: On an unmask edge with the pending bit set and the vector deliverable, exactly one message is emitted. The pending bit stays set until that message is accepted and then clears, and a later edge does not replay it again.
- R9: A virtio reset pulse returns the config vector and all queue-map entries to 0xFFFF. Table contents, pending bits, enable and function mask are unchanged.
- R10: Reads of table entries or pending bytes outside the implemented range return 0, and a queue-map read outside range returns 0xFFFF. Writes outside the range are ignored.
- R11: msg_valid, msg_addr and msg_data hold stable until msg_ready. While a message is outstanding, neither request is accepted.
- R12: When config and queue requests are both valid, the config request is accepted first. The queue request is held off (q_req_ready low) until a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_space | input | 3 | Register space: 0 table, 1 pending bytes, 2 message control, 3 config vector, 4 queue map |
| reg_idx | input | 16 | Table entry, pending byte or queue index |
| reg_dw | input | 2 | Dword within a table entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the addressed register |
| virtio_reset | input | 1 | Clears vector assignments |
| cc_req_valid | input | 1 | Configuration-change request |
| cc_req_ready | output | 1 | Config request accepted this cycle |
| q_req_valid | input | 1 | Queue-completion request |
| q_req_idx | input | 16 | Queue index of the request |
| q_req_ready | output | 1 | Queue request accepted this cycle |
| msg_valid | output | 1 | Message write pending |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_ready | input | 1 | Message taken |

## Verification
Two things can meet in one cycle. The first is a pair of requests: config-change and queue completion asserted together. The bench raises both on the same edge while msg_ready is held low. It checks that the config vector's message appears first and stays put, and that q_req_ready stays low. Only after the handshake does the queue's vector appear. The second is a replay handshake meeting new traffic. The bench judges this from the pending byte, which still shows the bit while the replayed message is outstanding and shows it clear right after acceptance.

// File: rtl/msix_gate_pkg.sv
package msix_gate_pkg;

    // All-ones vector code: source not connected to any vector.
    localparam logic [15:0] VEC_NONE = 16'hFFFF;

    typedef enum logic [2:0] {
        SPACE_TABLE = 3'd0,
        SPACE_PEND  = 3'd1,
        SPACE_MCTL  = 3'd2,
        SPACE_CVEC  = 3'd3,
        SPACE_QMAP  = 3'd4
    } reg_space_e;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] data;
        logic [31:0] ahi;
        logic [31:0] alo;
    } vec_entry_t;

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_gate_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_entry,
    input  logic [1:0]         wr_dw,
    input  logic [31:0]        wr_data,
    input  logic [15:0]        rd_entry,
    input  logic [1:0]         rd_dw,
    output logic [31:0]        rd_data,
    input  logic [15:0]        lk_vec,
    output logic [63:0]        lk_addr,
    output logic [31:0]        lk_data,
    output logic [NUM_VEC-1:0] mask_o,
    output logic               unmask_edge_o,
    output logic [15:0]        unmask_vec_o
);

    vec_entry_t [NUM_VEC-1:0] ent_d, ent_q;

    always_comb begin
        ent_d         = ent_q;
        unmask_edge_o = 1'b0;
        unmask_vec_o  = wr_entry;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (wr_en && wr_entry == 16'(v)) begin
                case (wr_dw)
                    2'd0: ent_d[v].alo  = wr_data;
                    2'd1: ent_d[v].ahi  = wr_data;
                    2'd2: ent_d[v].data = wr_data;
                    default: begin
                        ent_d[v].ctl = wr_data;
                        if (ent_q[v].ctl[0] && !wr_data[0]) unmask_edge_o = 1'b1;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        lk_addr = '0;
        lk_data = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            mask_o[v] = ent_q[v].ctl[0];
            if (rd_entry == 16'(v)) begin
                case (rd_dw)
                    2'd0:    rd_data = ent_q[v].alo;
                    2'd1:    rd_data = ent_q[v].ahi;
                    2'd2:    rd_data = ent_q[v].data;
                    default: rd_data = ent_q[v].ctl;
                endcase
            end
            if (lk_vec == 16'(v)) begin
                lk_addr = {ent_q[v].ahi, ent_q[v].alo};
                lk_data = ent_q[v].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++)
                ent_q[v] <= '{ctl: 32'd1, data: '0, ahi: '0, alo: '0};
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask_chk
        assert_unmask_by_ctl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mask_o[g]) |-> $past(wr_en && wr_dw == 2'd3 && wr_entry == 16'(g)));
    end

endmodule

// File: rtl/msix_src_map.sv
module msix_src_map
    import msix_gate_pkg::*;
#(
    parameter int NUM_QUEUES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vreset,
    input  logic        cvec_we,
    input  logic        qmap_we,
    input  logic [15:0] wr_qidx,
    input  logic [15:0] wr_data,
    input  logic [15:0] rd_qidx,
    output logic [15:0] rd_qvec,
    output logic [15:0] cvec_o,
    input  logic [15:0] lk_qidx,
    output logic [15:0] lk_qvec
);

    typedef struct packed {
        logic [15:0]                  cvec;
        logic [NUM_QUEUES-1:0][15:0]  qv;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (cvec_we) map_d.cvec = wr_data;
        for (int i = 0; i < NUM_QUEUES; i++) begin
            if (qmap_we && wr_qidx == 16'(i)) map_d.qv[i] = wr_data;
        end
        if (vreset) begin
            map_d.cvec = VEC_NONE;
            for (int i = 0; i < NUM_QUEUES; i++) map_d.qv[i] = VEC_NONE;
        end
    end

    always_comb begin
        cvec_o  = map_q.cvec;
        rd_qvec = VEC_NONE;
        lk_qvec = VEC_NONE;
        for (int i = 0; i < NUM_QUEUES; i++) begin
            if (rd_qidx == 16'(i)) rd_qvec = map_q.qv[i];
            if (lk_qidx == 16'(i)) lk_qvec = map_q.qv[i];
        end
    end

    // Unconnected code is all ones, so reset fills the whole map with ones.
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '1;
        else        map_q <= map_d;
    end

    assert_vreset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |=> (cvec_o == VEC_NONE && lk_qvec == VEC_NONE && rd_qvec == VEC_NONE));

endmodule

// File: rtl/msix_delivery.sv
module msix_delivery
    import msix_gate_pkg::*;
#(
    parameter int NUM_VEC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mctl_we,
    input  logic               mctl_en_bit,
    input  logic               mctl_fm_bit,
    output logic               enable_o,
    output logic               fmask_o,
    input  logic [NUM_VEC-1:0] mask_i,
    input  logic               unmask_edge_i,
    input  logic [15:0]        unmask_vec_i,
    input  logic               cc_req_valid,
    input  logic [15:0]        cc_req_vec,
    input  logic               q_req_valid,
    input  logic [15:0]        q_req_vec,
    output logic               cc_req_ready,
    output logic               q_req_ready,
    output logic [15:0]        lk_vec,
    input  logic [63:0]        lk_addr,
    input  logic [31:0]        lk_data,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    input  logic               msg_ready,
    output logic [NUM_VEC-1:0] pend_o
);

    typedef struct packed {
        logic               en;
        logic               fm;
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] rpl;
        logic               busy;
        logic               is_rpl;
        logic [15:0]        vec;
        logic [63:0]        addr;
        logic [31:0]        data;
    } dlv_t;

    dlv_t st_d, st_q;
    logic        any_rpl;
    logic        open;
    logic [15:0] pick;
    logic [15:0] req_vec;

    always_comb begin
        any_rpl = |st_q.rpl;
        pick    = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (st_q.rpl[v]) pick = 16'(v);
        end
        req_vec = cc_req_valid ? cc_req_vec : q_req_vec;
        lk_vec  = any_rpl ? pick : req_vec;
        open    = !st_q.busy && !any_rpl;

        st_d = st_q;
        if (mctl_we) begin
            st_d.en = mctl_en_bit;
            st_d.fm = mctl_fm_bit;
        end
        // Completion of the outstanding message; a replay retires its pending bit here.
        if (st_q.busy && msg_ready) begin
            st_d.busy = 1'b0;
            for (int v = 0; v < NUM_VEC; v++) begin
                if (st_q.is_rpl && st_q.vec == 16'(v)) begin
                    st_d.pend[v] = 1'b0;
                    st_d.rpl[v]  = 1'b0;
                end
            end
        end
        if (unmask_edge_i) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (unmask_vec_i == 16'(v) && st_d.pend[v] && st_q.en && !st_q.fm)
                    st_d.rpl[v] = 1'b1;
            end
        end
        if (!st_q.busy && any_rpl) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (pick == 16'(v)) begin
                    if (st_q.en && !st_q.fm && !mask_i[v]) begin
                        st_d.busy   = 1'b1;
                        st_d.is_rpl = 1'b1;
                        st_d.vec    = 16'(v);
                        st_d.addr   = lk_addr;
                        st_d.data   = lk_data;
                    end else begin
                        st_d.rpl[v] = 1'b0;
                    end
                end
            end
        end else if (open && (cc_req_valid || q_req_valid)) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (req_vec == 16'(v) && st_q.en) begin
                    if (st_q.fm || mask_i[v]) begin
                        st_d.pend[v] = 1'b1;
                    end else begin
                        st_d.busy   = 1'b1;
                        st_d.is_rpl = 1'b0;
                        st_d.vec    = 16'(v);
                        st_d.addr   = lk_addr;
                        st_d.data   = lk_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_req_ready = open;
    assign q_req_ready  = open && !cc_req_valid;
    assign msg_valid    = st_q.busy;
    assign msg_addr     = st_q.addr;
    assign msg_data     = st_q.data;
    assign enable_o     = st_q.en;
    assign fmask_o      = st_q.fm;
    assign pend_o       = st_q.pend;

    assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_cfg_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q_req_valid && q_req_ready) |-> !cc_req_valid);

    assert_no_msg_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(st_q.en));

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_pend_chk
        assert_pend_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[g]) |-> $past(st_q.fm || mask_i[g]));
        assert_pend_clear_on_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.pend[g]) |-> $past(st_q.busy && msg_ready && st_q.is_rpl));
    end

endmodule

// File: rtl/msix_vector_gate.sv
module msix_vector_gate
    import msix_gate_pkg::*;
#(
    parameter int NUM_QUEUES  = 6,
    parameter int MAX_VECTORS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_space,
    input  logic [15:0] reg_idx,
    input  logic [1:0]  reg_dw,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        virtio_reset,
    input  logic        cc_req_valid,
    output logic        cc_req_ready,
    input  logic        q_req_valid,
    input  logic [15:0] q_req_idx,
    output logic        q_req_ready,
    output logic        msg_valid,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    input  logic        msg_ready
);

    localparam int NUM_VEC = (NUM_QUEUES + 1 < MAX_VECTORS) ? NUM_QUEUES + 1 : MAX_VECTORS;

    reg_space_e         space;
    logic [31:0]        tbl_rd;
    logic [15:0]        lk_vec;
    logic [63:0]        lk_addr;
    logic [31:0]        lk_data;
    logic [NUM_VEC-1:0] mask;
    logic               unmask_edge;
    logic [15:0]        unmask_vec;
    logic [15:0]        qmap_rd;
    logic [15:0]        cvec;
    logic [15:0]        q_vec;
    logic               enable;
    logic               fmask;
    logic [NUM_VEC-1:0] pend;

    assign space = reg_space_e'(reg_space);

    msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_we && space == SPACE_TABLE),
        .wr_entry      (reg_idx),
        .wr_dw         (reg_dw),
        .wr_data       (reg_wdata),
        .rd_entry      (reg_idx),
        .rd_dw         (reg_dw),
        .rd_data       (tbl_rd),
        .lk_vec        (lk_vec),
        .lk_addr       (lk_addr),
        .lk_data       (lk_data),
        .mask_o        (mask),
        .unmask_edge_o (unmask_edge),
        .unmask_vec_o  (unmask_vec)
    );

    msix_src_map #(.NUM_QUEUES(NUM_QUEUES)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .vreset  (virtio_reset),
        .cvec_we (reg_we && space == SPACE_CVEC),
        .qmap_we (reg_we && space == SPACE_QMAP),
        .wr_qidx (reg_idx),
        .wr_data (reg_wdata[15:0]),
        .rd_qidx (reg_idx),
        .rd_qvec (qmap_rd),
        .cvec_o  (cvec),
        .lk_qidx (q_req_idx),
        .lk_qvec (q_vec)
    );

    msix_delivery #(.NUM_VEC(NUM_VEC)) u_dlv (
        .clk           (clk),
        .rst_n         (rst_n),
        .mctl_we       (reg_we && space == SPACE_MCTL),
        .mctl_en_bit   (reg_wdata[15]),
        .mctl_fm_bit   (reg_wdata[14]),
        .enable_o      (enable),
        .fmask_o       (fmask),
        .mask_i        (mask),
        .unmask_edge_i (unmask_edge),
        .unmask_vec_i  (unmask_vec),
        .cc_req_valid  (cc_req_valid),
        .cc_req_vec    (cvec),
        .q_req_valid   (q_req_valid),
        .q_req_vec     (q_vec),
        .cc_req_ready  (cc_req_ready),
        .q_req_ready   (q_req_ready),
        .lk_vec        (lk_vec),
        .lk_addr       (lk_addr),
        .lk_data       (lk_data),
        .msg_valid     (msg_valid),
        .msg_addr      (msg_addr),
        .msg_data      (msg_data),
        .msg_ready     (msg_ready),
        .pend_o        (pend)
    );

    always_comb begin
        reg_rdata = '0;
        case (space)
            SPACE_TABLE: reg_rdata = tbl_rd;
            SPACE_PEND: begin
                for (int v = 0; v < NUM_VEC; v++) begin
                    if (reg_idx == 16'(v / 8)) reg_rdata[v % 8] = pend[v];
                end
            end
            SPACE_MCTL: reg_rdata = {16'd0, enable, fmask, 14'd0};
            SPACE_CVEC: reg_rdata = {16'd0, cvec};
            SPACE_QMAP: reg_rdata = {16'd0, qmap_rd};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/msix_vector_gate_tb.sv
module msix_vector_gate_tb;

    localparam int NV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_space = '0;
    logic [15:0] reg_idx = '0;
    logic [1:0]  reg_dw = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        virtio_reset = 1'b0;
    logic        cc_req_valid = 1'b0;
    logic        cc_req_ready;
    logic        q_req_valid = 1'b0;
    logic [15:0] q_req_idx = '0;
    logic        q_req_ready;
    logic        msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        msg_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msix_vector_gate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_space(reg_space),
        .reg_idx(reg_idx), .reg_dw(reg_dw), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .virtio_reset(virtio_reset), .cc_req_valid(cc_req_valid), .cc_req_ready(cc_req_ready),
        .q_req_valid(q_req_valid), .q_req_idx(q_req_idx), .q_req_ready(q_req_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ready(msg_ready)
    );

    function automatic logic [63:0] exp_addr(input int v);
        return {32'(v), 32'hFEE0_0000 + 32'(v * 16)};
    endfunction

    function automatic logic [31:0] exp_data(input int v);
        return 32'h4000 + 32'(v);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sp, input int idx, input int dw, input logic [31:0] d);
        reg_we = 1'b1; reg_space = sp; reg_idx = 16'(idx); reg_dw = 2'(dw); reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sp, input int idx, input int dw, output logic [31:0] d);
        reg_space = sp; reg_idx = 16'(idx); reg_dw = 2'(dw);
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sp, input int idx, input int dw, input logic [31:0] exp);
        logic [31:0] d;
        rd(sp, idx, dw, d);
        chk(req, $sformatf("read sp%0d idx%0d dw%0d", sp, idx, dw), 64'(d), 64'(exp));
    endtask

    task automatic fire_q(input int qi);
        q_req_valid = 1'b1; q_req_idx = 16'(qi);
        tick();
        q_req_valid = 1'b0;
    endtask

    task automatic fire_cc();
        cc_req_valid = 1'b1;
        tick();
        cc_req_valid = 1'b0;
    endtask

    task automatic take_msg(input string req, input int v);
        chk(req, "msg_valid", 64'(msg_valid), 64'd1);
        chk(req, "msg_addr", msg_addr, exp_addr(v));
        chk(req, "msg_data", 64'(msg_data), 64'(exp_data(v)));
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
    endtask

    task automatic no_msg(input string req);
        chk(req, "no message", 64'(msg_valid), 64'd0);
    endtask

    // R1, R2, R10: reset state and implemented range
    task automatic t_reset();
        for (int v = 0; v < NV; v++) begin
            rd_chk("R1", 3'd0, v, 3, 32'd1);
            rd_chk("R1", 3'd0, v, 2, 32'd0);
        end
        rd_chk("R1", 3'd2, 0, 0, 32'd0);
        rd_chk("R1", 3'd3, 0, 0, 32'hFFFF);
        for (int q = 0; q < 6; q++) rd_chk("R1", 3'd4, q, 0, 32'hFFFF);
        rd_chk("R1", 3'd1, 0, 0, 32'd0);
        rd_chk("R2", 3'd0, NV, 3, 32'd0);
        no_msg("R1");
    endtask

    task automatic t_program();
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, v, 0, 32'hFEE0_0000 + 32'(v * 16));
            wr(3'd0, v, 1, 32'(v));
            wr(3'd0, v, 2, exp_data(v));
            wr(3'd0, v, 3, 32'd0);
        end
        wr(3'd2, 0, 0, 32'h8000);
        rd_chk("R3", 3'd2, 0, 0, 32'h8000);
        wr(3'd3, 0, 0, 32'd0);
        wr(3'd4, 0, 0, 32'd1);
        wr(3'd4, 1, 0, 32'd2);
        for (int q = 2; q < 6; q++) wr(3'd4, q, 0, 32'd3);
        rd_chk("R2", 3'd4, 5, 0, 32'd3);
        no_msg("R7");
    endtask

    // R4: routing through map and config vector
    task automatic t_route();
        fire_q(1);
        take_msg("R4", 2);
        no_msg("R4");
        fire_cc();
        take_msg("R4", 0);
        fire_q(4);
        take_msg("R4", 3);
        rd_chk("R4", 3'd1, 0, 0, 32'd0);
    endtask

    // R5: dropped requests
    task automatic t_drop();
        wr(3'd4, 0, 0, 32'hFFFF);
        fire_q(0);
        no_msg("R5");
        wr(3'd3, 0, 0, 32'd9);
        fire_cc();
        no_msg("R5");
        rd_chk("R5", 3'd1, 0, 0, 32'd0);
        wr(3'd3, 0, 0, 32'd0);
        wr(3'd4, 0, 0, 32'd1);
        wr(3'd2, 0, 0, 32'h0000);
        fire_q(1);
        no_msg("R5");
        rd_chk("R5", 3'd1, 0, 0, 32'd0);
        wr(3'd2, 0, 0, 32'h8000);
    endtask

    // R6, R7, R8: own mask, edges, replay
    task automatic t_mask();
        wr(3'd0, 2, 3, 32'd1);
        fire_q(1);
        no_msg("R6");
        rd_chk("R6", 3'd1, 0, 0, 32'h04);
        wr(3'd0, 2, 0, 32'hFEE0_0020);
        tick();
        no_msg("R7");
        wr(3'd0, 2, 3, 32'd1);
        tick();
        no_msg("R7");
        wr(3'd0, 2, 3, 32'd0);
        tick();
        rd_chk("R8", 3'd1, 0, 0, 32'h04);
        take_msg("R8", 2);
        rd_chk("R8", 3'd1, 0, 0, 32'h00);
        no_msg("R8");
        wr(3'd0, 2, 3, 32'd1);
        wr(3'd0, 2, 3, 32'd0);
        tick();
        no_msg("R8");
    endtask

    // R3, R6: function mask
    task automatic t_fmask();
        wr(3'd2, 0, 0, 32'hC000);
        rd_chk("R3", 3'd2, 0, 0, 32'hC000);
        fire_cc();
        fire_q(0);
        fire_q(2);
        no_msg("R3");
        rd_chk("R6", 3'd1, 0, 0, 32'h0B);
        wr(3'd2, 0, 0, 32'h8000);
        tick();
        no_msg("R7");
        rd_chk("R7", 3'd1, 0, 0, 32'h0B);
        wr(3'd0, 3, 3, 32'd1);
        wr(3'd0, 3, 3, 32'd0);
        tick();
        take_msg("R8", 3);
        rd_chk("R8", 3'd1, 0, 0, 32'h03);
    endtask

    // R11, R12: simultaneous requests under back-pressure
    task automatic t_same_cycle();
        cc_req_valid = 1'b1;
        q_req_valid  = 1'b1;
        q_req_idx    = 16'd1;
        #1;
        chk("R12", "q_req_ready with config valid", 64'(q_req_ready), 64'd0);
        chk("R12", "cc_req_ready idle", 64'(cc_req_ready), 64'd1);
        tick();
        cc_req_valid = 1'b0;
        #1;
        chk("R12", "config message first", 64'(msg_data), 64'(exp_data(0)));
        chk("R11", "q_req_ready while busy", 64'(q_req_ready), 64'd0);
        tick();
        chk("R11", "valid held", 64'(msg_valid), 64'd1);
        chk("R11", "addr held", msg_addr, exp_addr(0));
        chk("R11", "data held", 64'(msg_data), 64'(exp_data(0)));
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
        #1;
        chk("R12", "queue accepted after", 64'(q_req_ready), 64'd1);
        tick();
        q_req_valid = 1'b0;
        take_msg("R12", 2);
        no_msg("R11");
    endtask

    // R10, R2: out-of-range access
    task automatic t_range();
        wr(3'd0, 5, 2, 32'h1234);
        rd_chk("R10", 3'd0, 5, 2, 32'd0);
        rd_chk("R10", 3'd1, 1, 0, 32'd0);
        wr(3'd4, 6, 0, 32'd2);
        rd_chk("R10", 3'd4, 6, 0, 32'hFFFF);
        fire_q(5);
        take_msg("R2", 3);
    endtask

    // R9: virtio reset
    task automatic t_vreset();
        virtio_reset = 1'b1;
        tick();
        virtio_reset = 1'b0;
        rd_chk("R9", 3'd3, 0, 0, 32'hFFFF);
        rd_chk("R9", 3'd4, 0, 0, 32'hFFFF);
        rd_chk("R9", 3'd4, 5, 0, 32'hFFFF);
        rd_chk("R9", 3'd2, 0, 0, 32'h8000);
        rd_chk("R9", 3'd0, 2, 2, exp_data(2));
        rd_chk("R9", 3'd0, 2, 3, 32'd0);
        rd_chk("R9", 3'd1, 0, 0, 32'h03);
        fire_q(1);
        no_msg("R9");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_route();
        t_drop();
        t_mask();
        t_fmask();
        t_same_cycle();
        t_range();
        t_vreset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule